// File: doc/BRIEF.md
# Programmable Pixel Color-Space Converter

This block sits in a display pipe and converts every three-component pixel that passes through it. Each input component first gets its own pre-offset. The three offset components are then multiplied by a programmable 3x3 matrix. Each result then gets either its own post-offset or a fixed black-level lift. Finally the result is rounded and saturated to the pixel range. The two settings that matter most in practice are an identity matrix, which leaves a full-range picture untouched, and a gain of about 219/255 plus a black lift, which turns full-range RGB into limited-range (16 to 235) RGB.

Software programs the block through a word-addressed write port. Every write lands in a shadow copy, and a one-cycle frame-start pulse copies the whole shadow set into the active set in one step. A frame therefore always runs with one consistent set of coefficients and offsets. Each pixel carries a bypass flag. A pixel with the flag set goes around the matrix with the same latency as a converted pixel, so bypassed and converted pixels can be mixed in one stream.

Top module: `csc_top`

## Requirements
- R1: Writes go to shadow storage only and leave the output unchanged until the next frame_start. The byte offsets (bits 1:0 ignored) are as follows. 0x10 holds matrix entries (row0,col0) in bits 31:16 and (row0,col1) in bits 15:0. 0x14 holds (row0,col2) in bits 31:16. 0x18 and 0x1C hold row 1 in the same layout, and 0x20 and 0x24 hold row 2. The mode word is at 0x28. The pre-offsets for components 0, 1 and 2 are at 0x30, 0x34 and 0x38, and the post-offsets for those components are at 0x40, 0x44 and 0x48. Writes to other offsets have no effect.
- R2: frame_start copies every shadow setting into the active set at the next clock edge. If a write arrives in the same cycle as frame_start, that write is not part of the copy; it becomes active at the following frame_start.
- R3: Each 16-bit coefficient is built as follows. Bit 15 is the sign. Bits 14:12 are an exponent code: 0 means x1, 1 means x1/2, 2 means x1/4, 3 means x1/8, 6 means x4, 7 means x2, and codes 4 and 5 give a zero coefficient. Bits 11:3 are a mantissa m read as m/512. Bits 2:0 are ignored. So 0x7800 is exactly 1.0 and 0x0DB8 is 439/512.
- R4: With 0x7800 at the three diagonal positions, every other coefficient zero, and zero offsets, each component passes through unchanged.
- R5: The pre-offsets are 13-bit two's-complement values (bits 12:0) in units of 1/8 of an output code. Each one is added to its input component before the multiply.
- R6: The post-offsets are 13-bit two's-complement values (bits 12:0) in units of 1/8 code, so 8192 spans the full 1024-code range. When mode bit 2 is clear, each one is added to its matrix row result.
- R7: When mode bit 2 is set, a fixed lift of 64 codes (16 on an 8-bit scale) replaces the post-offsets on all three rows. Mode bits 0 and 1 have no effect on pixel values.
- R8: Each output is round-half-up of the exact sum (matrix product plus offset), saturated to 0..1023.
- R9: pix_valid_o repeats pix_valid_i exactly three cycles later, and the data of a valid pixel appears in that same cycle.
- R10: A valid pixel with pix_bypass_i set comes out three cycles later with all three components equal to its inputs, whatever the active settings are.
- R11: After reset, pix_valid_o is low, all outputs are zero, and every setting is zero, so a converted pixel comes out as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register written |
| reg_wdata | input | 32 | Write data |
| frame_start | input | 1 | Pulse that loads shadow settings into the active set |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_bypass_i | input | 1 | Route this pixel around the matrix |
| pix_c0_i | input | 10 | Input component 0 |
| pix_c1_i | input | 10 | Input component 1 |
| pix_c2_i | input | 10 | Input component 2 |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_c0_o | output | 10 | Output component 0 |
| pix_c1_o | output | 10 | Output component 1 |
| pix_c2_o | output | 10 | Output component 2 |

## Verification
A register write and a frame_start load can happen in the same clock cycle. The bench provokes this by putting a write that zeroes row 0 on the very cycle of the frame-start pulse. It then checks two things. First, pixels in the frame that follows still go through the old identity row. Second, pixels only lose component 0 after a second frame_start with no write beside it. The result is judged at the output pins against a model that applies the load before the write.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int NUM_CH    = 3;
    localparam int COEF_W    = 16;
    localparam int OFF_W     = 13;
    localparam int OFF_FRAC  = 3;
    localparam int COEF_FRAC = 12;
    localparam int MANT_W    = 9;
    localparam int CINT_W    = 16;
    localparam int REG_AW    = 8;
    localparam int REG_DW    = 32;

    localparam int SIGN_BIT  = 15;
    localparam int EXP_HI    = 14;
    localparam int EXP_LO    = 12;
    localparam int MANT_HI   = 11;
    localparam int MANT_LO   = 3;

    typedef struct packed {
        logic                                   black;
        logic [NUM_CH-1:0][OFF_W-1:0]           post;
        logic [NUM_CH-1:0][OFF_W-1:0]           pre;
        logic [NUM_CH*NUM_CH-1:0][COEF_W-1:0]   coef;
    } csc_cfg_t;

    localparam int CFG_W = $bits(csc_cfg_t);

    // Signed coefficient in units of 2^-COEF_FRAC
    function automatic logic signed [CINT_W-1:0] coef_decode(input logic [COEF_W-1:0] raw);
        logic [CINT_W-1:0] mag;
        logic [CINT_W-1:0] man;
        logic              unused_lsb;
        unused_lsb = ^raw[MANT_LO-1:0];
        man = CINT_W'(raw[MANT_HI:MANT_LO]);
        case (raw[EXP_HI:EXP_LO])
            3'd0:    mag = man << 3;
            3'd1:    mag = man << 2;
            3'd2:    mag = man << 1;
            3'd3:    mag = man;
            3'd6:    mag = man << 5;
            3'd7:    mag = man << 4;
            default: mag = '0;
        endcase
        return raw[SIGN_BIT] ? -$signed(mag) : $signed(mag);
    endfunction

endpackage

// File: rtl/csc_regs.sv
module csc_regs
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              frame_start,
    output csc_cfg_t          sh_cfg,
    output csc_cfg_t          act_cfg
);

    localparam int           IDX_W     = REG_AW - 2;
    localparam int           IDX_COEF  = 4;
    localparam logic [IDX_W-1:0] IDX_MODE = IDX_W'(10);
    localparam int           IDX_PRE   = 12;
    localparam int           IDX_POST  = 16;
    localparam int           BLACK_BIT = 2;
    localparam int           HALF      = REG_DW / 2;

    typedef struct packed {
        csc_cfg_t sh;
        csc_cfg_t act;
    } regs_st_t;

    regs_st_t         st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic             unused_addr;

    assign idx         = wr_addr[REG_AW-1:2];
    assign unused_addr = ^wr_addr[1:0];

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.act = st_q.sh;
        end
        if (wr_en) begin
            for (int r = 0; r < NUM_CH; r++) begin
                if (idx == IDX_W'(IDX_COEF + 2*r)) begin
                    st_d.sh.coef[NUM_CH*r]     = wr_data[REG_DW-1:HALF];
                    st_d.sh.coef[NUM_CH*r + 1] = wr_data[HALF-1:0];
                end
                if (idx == IDX_W'(IDX_COEF + 2*r + 1)) begin
                    st_d.sh.coef[NUM_CH*r + 2] = wr_data[REG_DW-1:HALF];
                end
                if (idx == IDX_W'(IDX_PRE + r)) begin
                    st_d.sh.pre[r] = wr_data[OFF_W-1:0];
                end
                if (idx == IDX_W'(IDX_POST + r)) begin
                    st_d.sh.post[r] = wr_data[OFF_W-1:0];
                end
            end
            if (idx == IDX_MODE) begin
                st_d.sh.black = wr_data[BLACK_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sh_cfg  = st_q.sh;
    assign act_cfg = st_q.act;

endmodule

// File: rtl/csc_row.sv
module csc_row
    import csc_pkg::*;
#(
    parameter  int PIX_W = 10,
    localparam int P_W   = PIX_W + OFF_FRAC + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0][P_W-1:0]    p_i,
    input  logic [NUM_CH-1:0][COEF_W-1:0] coef_i,
    input  logic [OFF_W-1:0]              post_i,
    input  logic                          black_i,
    output logic [PIX_W-1:0]              y_o
);

    localparam int ACC_W = P_W + CINT_W + 4;
    localparam int SHIFT = OFF_FRAC + COEF_FRAC;
    localparam logic signed [ACC_W-1:0] BLACK_ACC = ACC_W'(longint'(16) <<< (PIX_W - 8 + SHIFT));
    localparam logic signed [ACC_W-1:0] ROUND_ACC = ACC_W'(longint'(1) <<< (SHIFT - 1));
    localparam logic signed [ACC_W-1:0] MAX_Y     = ACC_W'((longint'(1) <<< PIX_W) - 1);

    logic signed [ACC_W-1:0] acc_d, acc_q;
    logic signed [ACC_W-1:0] off_d, sum_d, shf_d;

    // stage 2: dot product of one matrix row
    always_comb begin
        acc_d = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            acc_d = acc_d + ACC_W'($signed(p_i[c])) * ACC_W'(coef_decode(coef_i[c]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // stage 3 next value: offset, round, saturate
    always_comb begin
        off_d = black_i ? BLACK_ACC : (ACC_W'($signed(post_i)) <<< COEF_FRAC);
        sum_d = acc_q + off_d + ROUND_ACC;
        shf_d = sum_d >>> SHIFT;
        if (shf_d[ACC_W-1]) begin
            y_o = '0;
        end else if (shf_d > MAX_Y) begin
            y_o = '1;
        end else begin
            y_o = shf_d[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/csc_top.sv
module csc_top
    import csc_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              frame_start,
    input  logic              pix_valid_i,
    input  logic              pix_bypass_i,
    input  logic [PIX_W-1:0]  pix_c0_i,
    input  logic [PIX_W-1:0]  pix_c1_i,
    input  logic [PIX_W-1:0]  pix_c2_i,
    output logic              pix_valid_o,
    output logic [PIX_W-1:0]  pix_c0_o,
    output logic [PIX_W-1:0]  pix_c1_o,
    output logic [PIX_W-1:0]  pix_c2_o
);

    localparam int P_W = PIX_W + OFF_FRAC + 2;

    typedef logic [NUM_CH-1:0][PIX_W-1:0] pix_t;

    typedef struct packed {
        logic                       s1_v;
        logic                       s1_b;
        logic [NUM_CH-1:0][P_W-1:0] s1_p;
        pix_t                       s1_x;
        logic                       s2_v;
        logic                       s2_b;
        pix_t                       s2_x;
        logic                       o_v;
        pix_t                       o_y;
    } top_st_t;

    top_st_t  st_d, st_q;
    csc_cfg_t cfg_sh, cfg_act;
    pix_t     pix_in, row_y;

    assign pix_in = {pix_c2_i, pix_c1_i, pix_c0_i};

    csc_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_addr     (reg_addr),
        .wr_data     (reg_wdata),
        .frame_start (frame_start),
        .sh_cfg      (cfg_sh),
        .act_cfg     (cfg_act)
    );

    for (genvar r = 0; r < NUM_CH; r++) begin : g_row
        csc_row #(.PIX_W(PIX_W)) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .p_i     (st_q.s1_p),
            .coef_i  (cfg_act.coef[NUM_CH*r +: NUM_CH]),
            .post_i  (cfg_act.post[r]),
            .black_i (cfg_act.black),
            .y_o     (row_y[r])
        );
    end

    always_comb begin
        st_d      = st_q;
        // stage 1: pre-offset
        st_d.s1_v = pix_valid_i;
        st_d.s1_b = pix_bypass_i;
        st_d.s1_x = pix_in;
        for (int c = 0; c < NUM_CH; c++) begin
            st_d.s1_p[c] = P_W'({pix_in[c], {OFF_FRAC{1'b0}}}) + P_W'($signed(cfg_act.pre[c]));
        end
        // stage 2: side path alongside the row accumulators
        st_d.s2_v = st_q.s1_v;
        st_d.s2_b = st_q.s1_b;
        st_d.s2_x = st_q.s1_x;
        // stage 3: output select
        st_d.o_v  = st_q.s2_v;
        st_d.o_y  = st_q.s2_b ? st_q.s2_x : row_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_valid_o = st_q.o_v;
    assign pix_c0_o    = st_q.o_y[0];
    assign pix_c1_o    = st_q.o_y[1];
    assign pix_c2_o    = st_q.o_y[2];

endmodule

// File: rtl/csc_chk.sv
module csc_chk
    import csc_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             pix_valid_i,
    input logic             pix_bypass_i,
    input logic [PIX_W-1:0] pix_c0_i,
    input logic [PIX_W-1:0] pix_c1_i,
    input logic [PIX_W-1:0] pix_c2_i,
    input logic             pix_valid_o,
    input logic [PIX_W-1:0] pix_c0_o,
    input logic [PIX_W-1:0] pix_c1_o,
    input logic [PIX_W-1:0] pix_c2_o,
    input logic [CFG_W-1:0] act_cfg,
    input logic [CFG_W-1:0] sh_cfg
);

    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != 2'd3) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3) |-> (pix_valid_o == $past(pix_valid_i, 3))); // R9

    AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3 && pix_valid_o && $past(pix_bypass_i, 3)) |->
        (pix_c0_o == $past(pix_c0_i, 3) && pix_c1_o == $past(pix_c1_i, 3) &&
         pix_c2_o == $past(pix_c2_i, 3))); // R10

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 2'd0 && !$past(frame_start)) |-> $stable(act_cfg)); // R1

    AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 2'd0 && $past(frame_start)) |-> (act_cfg == $past(sh_cfg))); // R2

endmodule

bind csc_top csc_chk #(.PIX_W(PIX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .pix_valid_i  (pix_valid_i),
    .pix_bypass_i (pix_bypass_i),
    .pix_c0_i     (pix_c0_i),
    .pix_c1_i     (pix_c1_i),
    .pix_c2_i     (pix_c2_i),
    .pix_valid_o  (pix_valid_o),
    .pix_c0_o     (pix_c0_o),
    .pix_c1_o     (pix_c1_o),
    .pix_c2_o     (pix_c2_o),
    .act_cfg      (cfg_act),
    .sh_cfg       (cfg_sh)
);

// File: tb/csc_top_tb_top.sv
module csc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic        pix_bypass_i = 1'b0;
    logic [9:0]  pix_c0_i = '0, pix_c1_i = '0, pix_c2_i = '0;
    logic        pix_valid_o;
    logic [9:0]  pix_c0_o, pix_c1_o, pix_c2_o;

    always #5 clk = ~clk;

    csc_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .pix_valid_i(pix_valid_i),
        .pix_bypass_i(pix_bypass_i), .pix_c0_i(pix_c0_i), .pix_c1_i(pix_c1_i),
        .pix_c2_i(pix_c2_i), .pix_valid_o(pix_valid_o), .pix_c0_o(pix_c0_o),
        .pix_c1_o(pix_c1_o), .pix_c2_o(pix_c2_o)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit [31:0]   sh_w  [0:18];
    bit [31:0]   act_w [0:18];
    bit          e_v   [0:2];
    int          e_y   [0:2][0:2];
    string       e_tag [0:2];
    bit          n_wr = 0;
    bit          n_fs = 0;
    bit [7:0]    n_addr = '0;
    bit [31:0]   n_wdata = '0;

    function automatic longint s13(bit [12:0] v);
        return v[12] ? longint'(v) - 64'sd8192 : longint'(v);
    endfunction

    function automatic longint dec(bit [15:0] h);
        longint m = longint'(h[11:3]);
        longint g;
        case (h[14:12])
            3'd0: g = m * 8;
            3'd1: g = m * 4;
            3'd2: g = m * 2;
            3'd3: g = m;
            3'd6: g = m * 32;
            3'd7: g = m * 16;
            default: g = 0;
        endcase
        return h[15] ? -g : g;
    endfunction

    function automatic int model(int r, int x0, int x1, int x2);
        longint acc = 0;
        longint y;
        int     xs [0:2];
        xs[0] = x0; xs[1] = x1; xs[2] = x2;
        for (int c = 0; c < 3; c++) begin
            bit [31:0] w = act_w[4 + 2*r + (c == 2 ? 1 : 0)];
            bit [15:0] h = (c == 1) ? w[15:0] : w[31:16];
            acc += dec(h) * (longint'(xs[c]) * 8 + s13(act_w[12 + c][12:0]));
        end
        if (act_w[10][2]) acc += 64 * 32768;
        else              acc += s13(act_w[16 + r][12:0]) * 4096;
        y = (acc + 16384) >>> 15;
        if (y < 0)    y = 0;
        if (y > 1023) y = 1023;
        return int'(y);
    endfunction

    task automatic step(input bit v, input bit bp, input int x0, input int x1, input int x2,
                        input string tag);
        int outs [0:2];
        @(negedge clk);
        outs[0] = int'(pix_c0_o); outs[1] = int'(pix_c1_o); outs[2] = int'(pix_c2_o);
        n_chk++;
        if (pix_valid_o !== e_v[2]) begin
            n_bad++;
            $display("FAIL %s (R9) valid: got %0b exp %0b", e_tag[2], pix_valid_o, e_v[2]);
        end
        if (e_v[2]) begin
            for (int ch = 0; ch < 3; ch++) begin
                n_chk++;
                if (outs[ch] != e_y[2][ch]) begin
                    n_bad++;
                    $display("FAIL %s ch%0d: got %0d exp %0d", e_tag[2], ch, outs[ch], e_y[2][ch]);
                end
            end
        end
        e_v[2] = e_v[1]; e_y[2] = e_y[1]; e_tag[2] = e_tag[1];
        e_v[1] = e_v[0]; e_y[1] = e_y[0]; e_tag[1] = e_tag[0];
        e_v[0] = v; e_tag[0] = tag;
        e_y[0][0] = bp ? x0 : model(0, x0, x1, x2);
        e_y[0][1] = bp ? x1 : model(1, x0, x1, x2);
        e_y[0][2] = bp ? x2 : model(2, x0, x1, x2);
        if (n_fs) act_w = sh_w;
        if (n_wr && (n_addr >> 2) <= 18) sh_w[n_addr >> 2] = n_wdata;
        reg_wr_en    = n_wr;
        reg_addr     = n_addr;
        reg_wdata    = n_wdata;
        frame_start  = n_fs;
        pix_valid_i  = v;
        pix_bypass_i = bp;
        pix_c0_i = 10'(x0); pix_c1_i = 10'(x1); pix_c2_i = 10'(x2);
        n_wr = 0; n_fs = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "idle");
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        n_wr = 1; n_addr = a; n_wdata = d;
        step(0, 0, 0, 0, 0, "R1");
    endtask

    task automatic frame();
        idle(3);
        n_fs = 1;
        step(0, 0, 0, 0, 0, "R2");
    endtask

    task automatic set_diag(input bit [15:0] k);
        wr(8'h10, {k, 16'h0});
        wr(8'h14, 32'h0);
        wr(8'h18, {16'h0, k});
        wr(8'h1C, 32'h0);
        wr(8'h20, 32'h0);
        wr(8'h24, {k, 16'h0});
    endtask

    task automatic rnd_pix(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1, 0, int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
                 int'($urandom_range(0, 1023)), tag);
        end
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 19; i++) begin sh_w[i] = '0; act_w[i] = '0; end
        for (int i = 0; i < 3; i++) begin e_v[i] = 0; e_tag[i] = "R11"; end
        // R11: reset state at the pins
        repeat (3) @(negedge clk);
        n_chk++;
        if (pix_valid_o !== 1'b0 || pix_c0_o !== '0 || pix_c1_o !== '0 || pix_c2_o !== '0) begin
            n_bad++;
            $display("FAIL R11 reset outputs: got %0b/%0d/%0d/%0d exp 0/0/0/0",
                     pix_valid_o, pix_c0_o, pix_c1_o, pix_c2_o);
        end
        rst_n = 1'b1;
        // R11: zero settings give zero
        step(1, 0, 500, 600, 700, "R11");
        idle(3);
        // R1: shadow only
        set_diag(16'h7800);
        step(1, 0, 321, 654, 987, "R1");
        idle(3);
        // R4: identity
        frame();
        step(1, 0, 0, 0, 0, "R4");
        step(1, 0, 1023, 1023, 1023, "R4");
        rnd_pix(40, "R4");
        step(0, 0, 0, 0, 0, "R9");
        step(1, 1, 12, 34, 56, "R10");
        step(1, 0, 77, 88, 99, "R9");
        // R3/R6: limited-range gain plus post-offset 514
        set_diag(16'h0DB8);
        wr(8'h40, 32'd514); wr(8'h44, 32'd514); wr(8'h48, 32'd514);
        frame();
        step(1, 0, 0, 512, 1023, "R6");
        rnd_pix(20, "R3");
        // R7: black lift replaces post-offsets, bits 0/1 inert
        wr(8'h40, 32'd1000); wr(8'h28, 32'h7);
        frame();
        step(1, 0, 0, 0, 0, "R7");
        step(1, 0, 1023, 1023, 1023, "R7");
        rnd_pix(20, "R7");
        wr(8'h28, 32'h3);
        frame();
        rnd_pix(10, "R7");
        // R5/R8/R10: random settings, mixed bypass and gaps
        for (int f = 0; f < 6; f++) begin
            for (int a = 4; a <= 9; a++) wr(8'(a * 4), $urandom());
            for (int c = 0; c < 3; c++) begin
                wr(8'(8'h30 + 4*c), $urandom() & 32'h1FFF);
                wr(8'(8'h40 + 4*c), $urandom() & 32'h1FFF);
            end
            wr(8'h28, $urandom() & 32'h7);
            frame();
            for (int i = 0; i < 60; i++) begin
                bit v  = ($urandom_range(0, 4) != 0);
                bit bp = ($urandom_range(0, 3) == 0);
                step(v, bp, int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
                     int'($urandom_range(0, 1023)), bp ? "R10" : "R5/R8");
            end
        end
        // R8: saturation high and low, R3: exponent codes 4 and 5
        for (int c = 0; c < 3; c++) begin
            wr(8'(8'h30 + 4*c), 32'h0);
            wr(8'(8'h40 + 4*c), 32'h0);
        end
        wr(8'h28, 32'h0);
        set_diag(16'h6800);
        frame();
        step(1, 0, 1023, 100, 511, "R8");
        set_diag(16'hF800);
        frame();
        step(1, 0, 5, 600, 1023, "R8");
        set_diag(16'h4800);
        frame();
        step(1, 0, 700, 700, 700, "R3");
        set_diag(16'h5FF8);
        frame();
        step(1, 0, 700, 700, 700, "R3");
        // R2: write coinciding with frame_start
        set_diag(16'h7800);
        frame();
        idle(3);
        n_wr = 1; n_addr = 8'h10; n_wdata = 32'h0; n_fs = 1;
        step(0, 0, 0, 0, 0, "R2");
        step(1, 0, 300, 400, 500, "R2");
        frame();
        step(1, 0, 300, 400, 500, "R2");
        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule